// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block serialises bytes onto an asynchronous line. A host presents 8-bit data, with an optional ninth bit, through a one-cycle write strobe. The block frames each word with a low start bit and a high stop bit. The line is held for one period of an externally supplied baud tick per bit. A one-entry holding register can sit in front of the shift register, so the host can queue the next word while the current one is still on the line.

Three mode inputs set when the transmit interrupt flag rises. The first enables the holding register. The second places the flag either at the start or at the end of the stop bit. The third, used only with the holding register on, raises the flag after a final frame that has nothing queued behind it. The flag stays set until the host pulses a clear input. Writes that cannot be taken are dropped and recorded in a sticky overrun flag.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset, `txd` is 1 and `txIrq`, `holdFull` and `overrun` are 0.
- R2: A frame is a start bit at 0, then the data bits least significant bit first, then the ninth bit when `nineBitMode` is 1, then a stop bit at 1. Each bit lasts from one `baudTick` to the next, and the line is 1 between frames.
- R3: With `dblBufEn`=1, a write taken while a frame is on the line and the holding register is empty is stored and raises `holdFull`. When the stop bit ends, that word starts at once: the start bit appears in the cycle after the last stop-bit tick, and `holdFull` falls in the same cycle.
- R4: With `lateIrq`=0, `txIrq` rises in the same cycle that the line enters the stop bit.
- R5: With `lateIrq`=1, `txIrq` rises in the cycle after the tick that ends the stop bit.
- R6: With `dblBufEn`=1, a frame with no queued word and no write at the interrupt decision point raises `txIrq` only when `endIrqEn`=1.
- R7: With `dblBufEn`=0, the ninth bit is the value of `txBit9` sampled at the tick that enters the ninth-bit position, not its value at write time.
- R8: With `dblBufEn`=1, the ninth bit is the value of `txBit9` captured with the data at write time.
- R9: A write is dropped and sets the sticky `overrun` flag in two cases: `dblBufEn`=1 with the holding register full, or `dblBufEn`=0 with the shifter neither idle nor finishing its stop bit in that cycle.
- R10: With `dblBufEn`=1, a write in the same cycle as the interrupt decision (stop-bit entry when early, stop-bit end when late) counts as queued data. The flag is raised even with `endIrqEn`=0, and the word is sent next.
- R11: `txIrq` stays set until `irqClr` is pulsed. A set and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle pulse per bit period |
| wrEn | input | 1 | Write strobe for a data word |
| wrData | input | 8 | Data word |
| txBit9 | input | 1 | Ninth data bit |
| nineBitMode | input | 1 | Adds the ninth bit to each frame |
| dblBufEn | input | 1 | Enables the holding register |
| lateIrq | input | 1 | 0: flag at stop-bit start, 1: at stop-bit end |
| endIrqEn | input | 1 | Flag after a final frame (holding register mode) |
| irqClr | input | 1 | Clears the interrupt flag |
| txd | output | 1 | Serial line, idles high |
| txIrq | output | 1 | Transmit interrupt flag |
| holdFull | output | 1 | Holding register occupied |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
A wrong bit counter or a lost shift shows on `txd` within one bit period: the stop bit comes early or late, or a data bit carries the wrong value. A wrong holding-register state shows one of three ways. A stale `holdFull` makes the next write raise `overrun` at once. A frame that is not reloaded leaves the line high at the point where a start bit is due. An interrupt gate that misreads the queued state shows as a `txIrq` edge that is missing or extra at the stop-bit boundary. The bench compares all four outputs every cycle against its own model, so any of these faults appears in the cycle where it arises.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_BIT9  = 3'd3,
    ST_STOP  = 3'd4
  } txState_e;

  typedef struct packed {
    logic     holdCapture;
    logic     shLoadHold;
    logic     shLoadWr;
    logic     shShift;
    logic     bit9Sample;
    logic     irqSet;
    logic     ovrSet;
    txState_e line;
  } txStrobes_t;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       wrEn,
  input  logic       nineBitMode,
  input  logic       dblBufEn,
  input  logic       lateIrq,
  input  logic       endIrqEn,
  input  logic       holdFull,
  output txStrobes_t strb
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  txState_e         state, nextState;
  logic [CNT_W-1:0] bitCnt, nextCnt;

  logic busy, frameEnd, stopEnter, shFree, wrDropped, wrTaken;
  logic loadHold, loadWr, startFrame, pending, decide;

  always_comb begin
    busy      = (state != ST_IDLE);
    frameEnd  = (state == ST_STOP) && baudTick;
    stopEnter = baudTick &&
                (((state == ST_DATA) && (bitCnt == LAST_BIT) && !nineBitMode) ||
                 (state == ST_BIT9));
    shFree    = !busy || frameEnd;
    // write acceptance rules differ per buffering mode
    wrDropped = dblBufEn ? holdFull : !(shFree && !holdFull);
    wrTaken   = wrEn && !wrDropped;
    loadHold  = shFree && holdFull;
    loadWr    = wrTaken && shFree && !holdFull;
    startFrame = loadHold || loadWr;
    // a write landing on the decision cycle counts as queued data
    pending   = holdFull || wrEn;
    decide    = lateIrq ? frameEnd : stopEnter;
  end

  always_comb begin
    strb             = '0;
    strb.holdCapture = wrTaken && dblBufEn && !loadWr;
    strb.shLoadHold  = loadHold;
    strb.shLoadWr    = loadWr;
    strb.shShift     = (state == ST_DATA) && baudTick;
    strb.bit9Sample  = !dblBufEn && baudTick && (state == ST_DATA) &&
                       (bitCnt == LAST_BIT) && nineBitMode;
    strb.irqSet      = decide && (!dblBufEn || pending || endIrqEn);
    strb.ovrSet      = wrEn && wrDropped;
    strb.line        = state;
  end

  always_comb begin
    nextState = state;
    nextCnt   = bitCnt;
    unique case (state)
      ST_IDLE:  nextState = ST_IDLE;
      ST_START: if (baudTick) begin
                  nextState = ST_DATA;
                  nextCnt   = '0;
                end
      ST_DATA:  if (baudTick) begin
                  if (bitCnt == LAST_BIT)
                    nextState = nineBitMode ? ST_BIT9 : ST_STOP;
                  else
                    nextCnt = bitCnt + 1'b1;
                end
      ST_BIT9:  if (baudTick) nextState = ST_STOP;
      ST_STOP:  if (baudTick) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
    if (startFrame) nextState = ST_START;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= nextState;
      bitCnt <= nextCnt;
    end
  end

  AST_RELOAD_START: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && holdFull) |=> (state == ST_START)); // R3

endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txBit9,
  input  logic              irqClr,
  output logic              txd,
  output logic              txIrq,
  output logic              holdFull,
  output logic              overrun
);

  logic [DATA_W-1:0] holdData, shReg;
  logic              holdB9, shB9;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      holdB9   <= 1'b0;
      holdFull <= 1'b0;
    end else begin
      if (strb.holdCapture) begin
        holdData <= wrData;
        holdB9   <= txBit9;
        holdFull <= 1'b1;
      end else if (strb.shLoadHold) begin
        holdFull <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      shB9  <= 1'b0;
    end else begin
      if (strb.shLoadHold) begin
        shReg <= holdData;
        shB9  <= holdB9;
      end else if (strb.shLoadWr) begin
        shReg <= wrData;
        shB9  <= txBit9;
      end else begin
        if (strb.shShift)    shReg <= shReg >> 1;
        if (strb.bit9Sample) shB9  <= txBit9;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrq   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (strb.irqSet)      txIrq <= 1'b1;
      else if (irqClr)      txIrq <= 1'b0;
      if (strb.ovrSet)      overrun <= 1'b1;
    end
  end

  always_comb begin
    unique case (strb.line)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shReg[0];
      ST_BIT9:  txd = shB9;
      default:  txd = 1'b1;
    endcase
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && !strb.shLoadHold) |=> (holdFull && $stable(holdData))); // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun); // R9

  AST_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && !irqClr) |=> txIrq); // R11

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txBit9,
  input  logic              nineBitMode,
  input  logic              dblBufEn,
  input  logic              lateIrq,
  input  logic              endIrqEn,
  input  logic              irqClr,
  output logic              txd,
  output logic              txIrq,
  output logic              holdFull,
  output logic              overrun
);

  txStrobes_t strb;

  uart_tx_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .baudTick    (baudTick),
    .wrEn        (wrEn),
    .nineBitMode (nineBitMode),
    .dblBufEn    (dblBufEn),
    .lateIrq     (lateIrq),
    .endIrqEn    (endIrqEn),
    .holdFull    (holdFull),
    .strb        (strb)
  );

  uart_tx_dp #(.DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .txBit9   (txBit9),
    .irqClr   (irqClr),
    .txd      (txd),
    .txIrq    (txIrq),
    .holdFull (holdFull),
    .overrun  (overrun)
  );

  AST_EARLY_AT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (!lateIrq && $rose(txIrq)) |-> txd); // R4

endmodule

// File: tb/tb_dbuf_uart_tx.sv
module tb_dbuf_uart_tx;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0, wrEn = 1'b0, irqClr = 1'b0, txBit9 = 1'b0;
  logic nineBitMode = 1'b0, dblBufEn = 1'b0, lateIrq = 1'b0, endIrqEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic txd, txIrq, holdFull, overrun;

  always #10 clk = ~clk;

  dbuf_uart_tx dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrEn(wrEn), .wrData(wrData),
    .txBit9(txBit9), .nineBitMode(nineBitMode), .dblBufEn(dblBufEn),
    .lateIrq(lateIrq), .endIrqEn(endIrqEn), .irqClr(irqClr),
    .txd(txd), .txIrq(txIrq), .holdFull(holdFull), .overrun(overrun)
  );

  int checks = 0;
  int errors = 0;
  int tickCnt = 0;
  string curReq = "R1";

  // behavioural reference model
  int mBits [0:10];
  int mLen = 10, mPos = 0;
  bit mBusy = 0, mHoldV = 0, mHoldB9 = 0, mIrq = 0, mOvr = 0;
  logic [7:0] mHoldData = 0;

  function automatic void mLoad(logic [7:0] d, int b9);
    for (int i = 0; i < 8; i++) mBits[i+1] = int'(d[i]);
    mBits[0] = 0;
    if (nineBitMode) begin
      mBits[9] = b9;
      mBits[10] = 1;
      mLen = 11;
    end else begin
      mBits[9] = 1;
      mLen = 10;
    end
    mPos = 0;
    mBusy = 1;
  endfunction

  always @(posedge clk) begin : model
    bit fe, se, dec, free, holdBefore, tookHold;
    if (!rstN) begin
      mBusy = 0; mHoldV = 0; mIrq = 0; mOvr = 0; mPos = 0;
    end else begin
      fe = mBusy && baudTick && (mPos == mLen - 1);
      se = mBusy && baudTick && (mPos == mLen - 2);
      dec = lateIrq ? fe : se;
      if (dec && (!dblBufEn || mHoldV || wrEn || endIrqEn)) mIrq = 1;
      else if (irqClr) mIrq = 0;
      free = !mBusy || fe;
      holdBefore = mHoldV;
      tookHold = 0;
      if (mBusy && baudTick && !fe) begin
        mPos++;
        if (mBits[mPos] == 2) mBits[mPos] = int'(txBit9);
      end
      if (fe) mBusy = 0;
      if (free && mHoldV) begin
        mLoad(mHoldData, int'(mHoldB9));
        mHoldV = 0;
        tookHold = 1;
      end
      if (wrEn) begin
        if (dblBufEn) begin
          if (holdBefore) mOvr = 1;
          else if (free && !tookHold) mLoad(wrData, int'(txBit9));
          else begin mHoldV = 1; mHoldData = wrData; mHoldB9 = txBit9; end
        end else begin
          if (free && !holdBefore) mLoad(wrData, 2);
          else mOvr = 1;
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int expTxd;
    expTxd = mBusy ? mBits[mPos] : 1;
    check(int'(txd) == expTxd, curReq, "txd", int'(txd), expTxd);
    check(txIrq == mIrq, curReq, "txIrq", int'(txIrq), int'(mIrq));
    check(holdFull == mHoldV, curReq, "holdFull", int'(holdFull), int'(mHoldV));
    check(overrun == mOvr, curReq, "overrun", int'(overrun), int'(mOvr));
  endtask

  task automatic cyc(logic wr, logic [7:0] d, logic clr);
    @(negedge clk);
    compareAll();
    tickCnt = (tickCnt + 1) % 4;
    baudTick = (tickCnt == 0);
    wrEn = wr; wrData = d; irqClr = clr;
  endtask

  task automatic idle(int n);
    repeat (n) cyc(1'b0, 8'h00, 1'b0);
  endtask

  // write exactly on the interrupt decision cycle
  task automatic raceWrite(logic [7:0] d);
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      compareAll();
      tickCnt = (tickCnt + 1) % 4;
      baudTick = (tickCnt == 0);
      irqClr = 1'b0;
      wrData = d;
      wrEn = baudTick && mBusy && (lateIrq ? (mPos == mLen - 1) : (mPos == mLen - 2));
      if (wrEn) break;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    idle(3);
    rstN = 1'b1;
    curReq = "R1";
    idle(2);
    check(txd == 1'b1 && txIrq == 1'b0 && holdFull == 1'b0 && overrun == 1'b0,
          "R1", "reset state", int'({txd, txIrq, holdFull, overrun}), 8);

    curReq = "R2";   // single buffer, early flag
    cyc(1'b1, 8'hA5, 1'b0); idle(60);
    curReq = "R4";
    cyc(1'b1, 8'h5A, 1'b0); idle(60);
    curReq = "R11";
    check(txIrq == 1'b1, "R11", "flag held", int'(txIrq), 1);
    cyc(1'b0, 8'h00, 1'b1); idle(3);

    curReq = "R5"; lateIrq = 1'b1;
    cyc(1'b1, 8'h3C, 1'b0); idle(60);
    cyc(1'b0, 8'h00, 1'b1);

    curReq = "R7"; lateIrq = 1'b0; nineBitMode = 1'b1; txBit9 = 1'b0;
    cyc(1'b1, 8'hC3, 1'b0); idle(10); txBit9 = 1'b1; idle(60);
    cyc(1'b0, 8'h00, 1'b1);

    curReq = "R3"; nineBitMode = 1'b0; dblBufEn = 1'b1;
    cyc(1'b1, 8'h11, 1'b0); cyc(1'b1, 8'h22, 1'b0); idle(100);
    cyc(1'b0, 8'h00, 1'b1); idle(2);

    curReq = "R6";
    cyc(1'b1, 8'h81, 1'b0); idle(60);
    check(txIrq == 1'b0, "R6", "no end flag", int'(txIrq), 0);
    endIrqEn = 1'b1;
    cyc(1'b1, 8'h18, 1'b0); idle(60);
    check(txIrq == 1'b1, "R6", "end flag", int'(txIrq), 1);
    cyc(1'b0, 8'h00, 1'b1); endIrqEn = 1'b0; idle(2);

    curReq = "R8"; nineBitMode = 1'b1;
    txBit9 = 1'b0; cyc(1'b1, 8'h0F, 1'b0);
    txBit9 = 1'b1; cyc(1'b1, 8'hF0, 1'b0);
    txBit9 = 1'b0; idle(110);
    cyc(1'b0, 8'h00, 1'b1); nineBitMode = 1'b0; idle(2);

    curReq = "R10";
    cyc(1'b1, 8'h66, 1'b0); raceWrite(8'h99); idle(60);
    check(txIrq == 1'b1, "R10", "early race flag", int'(txIrq), 1);
    cyc(1'b0, 8'h00, 1'b1); lateIrq = 1'b1; idle(2);
    cyc(1'b1, 8'h77, 1'b0); raceWrite(8'hEE); idle(8);
    check(txIrq == 1'b1, "R10", "late race flag", int'(txIrq), 1);
    idle(60);
    cyc(1'b0, 8'h00, 1'b1); lateIrq = 1'b0; idle(2);

    curReq = "R9";
    cyc(1'b1, 8'h01, 1'b0); cyc(1'b1, 8'h02, 1'b0); cyc(1'b1, 8'h03, 1'b0);
    idle(2);
    check(overrun == 1'b1, "R9", "overrun double", int'(overrun), 1);
    idle(100);
    dblBufEn = 1'b0;
    cyc(1'b1, 8'h04, 1'b0); cyc(1'b1, 8'h05, 1'b0); idle(60);
    check(overrun == 1'b1, "R9", "overrun sticky", int'(overrun), 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule